// File: doc/BRIEF.md
# Parameter-Block Disk Command Engine

This block runs one disk command from start to finish. The host writes a seven-byte command descriptor into its own memory and pulses a start input with the descriptor's base address. The engine then becomes a bus master. It fetches the descriptor one byte at a time and decodes the operation, the drive, the record count, the track, the sector and the buffer address. It validates the request against the drive status inputs and the disk geometry, and then carries the command out.

Data commands move 128-byte sectors between host memory and a flat byte-addressed disk-image memory. The image offset is computed from track and sector. Positioning commands update a per-drive head-position register. Every command ends with a result type, an error byte and a set interrupt flip-flop, which the host clears through a dedicated input. Both memory ports move one byte per handshake and hold their request stable until the memory answers ready.

Top module: `pbde_engine`

## Requirements
- R1: After reset, busy_o=0, done_o=0, irq_o=0, res_type_o=2'b10, res_err_o=8'h00, and every drive's head position reads track 0, sector 0.
- R2: On an accepted start, the engine reads seven host bytes at base+0 through base+6, in address order. The bytes are: channel word (ignored), instruction, record count, track, sector, buffer address low, buffer address high. In the instruction byte, bits 2:0 hold the opcode (0 no-op, 1 seek, 2 format, 3 recalibrate, 4 read, 5 verify, 6 write, 7 write-deleted) and bits 5:4 hold the drive number.
- R3: If drive_ready_i of the selected drive is 0, the command ends with result type 2'b00 and error byte 8'h80. This check takes priority over every other check.
- R4: For every opcode except recalibrate, the command ends with result type 2'b00 and error byte 8'h08 if any of the following holds: sector = 0, sector > 52, sector + record count > 53, or track > 76.
- R5: Format, write and write-deleted on a drive whose drv_wprot_i bit is 1 end with result type 2'b00 and error byte 8'h20, and write nothing to the image. The address check (R4) is made before this check.
- R6: Write and write-deleted copy record-count × 128 bytes from the host buffer to the image. The copy starts at image offset ((track × 52) + sector − 1) × 128. Host address and image offset both advance by one per byte, so consecutive records land in consecutive sectors. Bytes outside that range are not touched.
- R7: Read copies record-count × 128 bytes from the image, starting at the same offset, to the host buffer. A record count of 0 completes without any transfer.
- R8: Format reads one fill byte from the buffer address and writes it to 52 × 128 = 6656 consecutive image bytes, starting at the computed offset.
- R9: Seek stores the track and the sector as the selected drive's head position. Recalibrate stores track 0 and the given sector, and is accepted even with an out-of-range track or sector. pos_trk_o and pos_sec_o show the position of the drive chosen by pos_sel_i.
- R10: Every successful completion (including no-op and verify, which do no transfer) posts result type 2'b10 and error byte 8'h00.
- R11: busy_o stays high from the cycle after an accepted start until completion. done_o pulses high for exactly one cycle, in which busy_o is already low. A start while busy is ignored.
- R12: irq_o rises only in a completion cycle and stays high until irq_clr_i is asserted. A completion in the same cycle as a clear wins over the clear.
- R13: Each memory port keeps its request, write enable, address and write data stable while its ready input is low, and moves exactly one byte per cycle in which both request and ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command (taken only when idle) |
| pb_base_i | input | 16 | Host address of the command descriptor |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hm_req_o | output | 1 | Host memory request |
| hm_we_o | output | 1 | Host memory write enable |
| hm_addr_o | output | 16 | Host memory byte address |
| hm_wdata_o | output | 8 | Host memory write data |
| hm_ready_i | input | 1 | Host memory ready; completes the current byte |
| hm_rdata_i | input | 8 | Host memory read data, valid with ready |
| im_req_o | output | 1 | Image memory request |
| im_we_o | output | 1 | Image memory write enable |
| im_off_o | output | 19 | Image byte offset |
| im_wdata_o | output | 8 | Image write data |
| im_ready_i | input | 1 | Image memory ready |
| im_rdata_i | input | 8 | Image read data, valid with ready |
| drv_ready_i | input | 4 | Per-drive ready status |
| drv_wprot_i | input | 4 | Per-drive write protect |
| irq_clr_i | input | 1 | Clear the interrupt flip-flop |
| res_type_o | output | 2 | Result type: 2'b10 success, 2'b00 error |
| res_err_o | output | 8 | Error byte of the last command |
| irq_o | output | 1 | Interrupt flip-flop |
| pos_sel_i | input | 2 | Drive whose head position is shown |
| pos_trk_o | output | 8 | Head track of the selected drive |
| pos_sec_o | output | 8 | Head sector of the selected drive |

## Verification
The hardest states to reach are those where several checks could fire at once. Examples are a not-ready drive with an illegal sector, a protected drive with an illegal address, and the last legal sector of the last track. Each of these has a dedicated descriptor with the fields chosen so that only the order of the checks decides the error byte. A second hard case is a transfer that stalls mid-record. Both memory models withhold ready in a pseudo-random pattern for the whole run, so byte boundaries and record boundaries often fall on stalled cycles. A further start is also pulsed during a running transfer, pointing at a descriptor that would produce a distinct error, to show it is not taken.

// File: rtl/pbde_pkg.sv
package pbde_pkg;

    localparam int HADDR_W = 16;
    localparam int PB_LAST = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_FILL,
        ST_FMT_WR,
        ST_RD_IMG,
        ST_WR_HOST,
        ST_RD_HOST,
        ST_WR_IMG
    } eng_state_e;

    localparam logic [2:0] OP_NOP    = 3'd0;
    localparam logic [2:0] OP_SEEK   = 3'd1;
    localparam logic [2:0] OP_FMT    = 3'd2;
    localparam logic [2:0] OP_RECAL  = 3'd3;
    localparam logic [2:0] OP_READ   = 3'd4;
    localparam logic [2:0] OP_VERIFY = 3'd5;
    localparam logic [2:0] OP_WRITE  = 3'd6;
    localparam logic [2:0] OP_WRDEL  = 3'd7;

    localparam logic [1:0] RT_FAIL = 2'b00;
    localparam logic [1:0] RT_DONE = 2'b10;

    localparam logic [7:0] EB_NONE  = 8'h00;
    localparam logic [7:0] EB_ADDR  = 8'h08;
    localparam logic [7:0] EB_WPROT = 8'h20;
    localparam logic [7:0] EB_NRDY  = 8'h80;

endpackage

// File: rtl/pbde_check.sv
module pbde_check
    import pbde_pkg::*;
#(
    parameter int NDRV     = 4,
    parameter int SPT      = 52,
    parameter int LAST_TRK = 76,
    parameter int DRV_W    = $clog2(NDRV)
) (
    input  logic [2:0]       op_i,
    input  logic [DRV_W-1:0] drv_i,
    input  logic [7:0]       nrec_i,
    input  logic [7:0]       trk_i,
    input  logic [7:0]       sec_i,
    input  logic [NDRV-1:0]  rdy_i,
    input  logic [NDRV-1:0]  wp_i,
    output logic             ok_o,
    output logic [7:0]       err_o
);

    logic [8:0] span;
    logic       addr_bad;
    logic       writes_media;

    always_comb begin
        span         = {1'b0, sec_i} + {1'b0, nrec_i};
        addr_bad     = (sec_i == 8'd0) || (sec_i > 8'(SPT)) ||
                       (span > 9'(SPT + 1)) || (trk_i > 8'(LAST_TRK));
        writes_media = (op_i == OP_FMT) || (op_i == OP_WRITE) || (op_i == OP_WRDEL);
        ok_o  = 1'b0;
        err_o = EB_NONE;
        // order of these tests is the priority of the error codes
        if (!rdy_i[drv_i]) begin
            err_o = EB_NRDY;
        end else if ((op_i != OP_RECAL) && addr_bad) begin
            err_o = EB_ADDR;
        end else if (writes_media && wp_i[drv_i]) begin
            err_o = EB_WPROT;
        end else begin
            ok_o = 1'b1;
        end
    end

endmodule

// File: rtl/pbde_offset.sv
module pbde_offset #(
    parameter int SPT       = 52,
    parameter int SEC_BYTES = 128,
    parameter int OFF_W     = 19
) (
    input  logic [7:0]       trk_i,
    input  logic [7:0]       sec_i,
    output logic [OFF_W-1:0] off_o
);

    logic [OFF_W-1:0] sec_index;

    always_comb begin
        sec_index = OFF_W'(trk_i) * OFF_W'(SPT) + OFF_W'(sec_i) - OFF_W'(1);
        off_o     = sec_index * OFF_W'(SEC_BYTES);
    end

endmodule

// File: rtl/pbde_headpos.sv
module pbde_headpos #(
    parameter int NDRV  = 4,
    parameter int DRV_W = $clog2(NDRV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [DRV_W-1:0] drv_i,
    input  logic [7:0]       trk_i,
    input  logic [7:0]       sec_i,
    input  logic [DRV_W-1:0] sel_i,
    output logic [7:0]       trk_o,
    output logic [7:0]       sec_o
);

    logic [7:0] trk_d [NDRV];
    logic [7:0] trk_q [NDRV];
    logic [7:0] sec_d [NDRV];
    logic [7:0] sec_q [NDRV];

    for (genvar g = 0; g < NDRV; g++) begin : g_drive
        always_comb begin
            trk_d[g] = trk_q[g];
            sec_d[g] = sec_q[g];
            if (upd_i && (drv_i == DRV_W'(g))) begin
                trk_d[g] = trk_i;
                sec_d[g] = sec_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trk_q[g] <= 8'd0;
                sec_q[g] <= 8'd0;
            end else begin
                trk_q[g] <= trk_d[g];
                sec_q[g] <= sec_d[g];
            end
        end
    end

    assign trk_o = trk_q[sel_i];
    assign sec_o = sec_q[sel_i];

    // R9: an update is visible on the outputs next cycle when selected
    a_r9_pos_update: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i && (sel_i == drv_i) && $stable(sel_i) |=> (trk_o == $past(trk_i)) && (sec_o == $past(sec_i)));

endmodule

// File: rtl/pbde_engine.sv
module pbde_engine
    import pbde_pkg::*;
#(
    parameter int NDRV      = 4,
    parameter int SEC_BYTES = 128,
    parameter int SPT       = 52,
    parameter int LAST_TRK  = 76,
    parameter int OFF_W     = $clog2((LAST_TRK + 1) * SPT * SEC_BYTES),
    parameter int DRV_W     = $clog2(NDRV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [HADDR_W-1:0] pb_base_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               hm_req_o,
    output logic               hm_we_o,
    output logic [HADDR_W-1:0] hm_addr_o,
    output logic [7:0]         hm_wdata_o,
    input  logic               hm_ready_i,
    input  logic [7:0]         hm_rdata_i,
    output logic               im_req_o,
    output logic               im_we_o,
    output logic [OFF_W-1:0]   im_off_o,
    output logic [7:0]         im_wdata_o,
    input  logic               im_ready_i,
    input  logic [7:0]         im_rdata_i,
    input  logic [NDRV-1:0]    drv_ready_i,
    input  logic [NDRV-1:0]    drv_wprot_i,
    input  logic               irq_clr_i,
    output logic [1:0]         res_type_o,
    output logic [7:0]         res_err_o,
    output logic               irq_o,
    input  logic [DRV_W-1:0]   pos_sel_i,
    output logic [7:0]         pos_trk_o,
    output logic [7:0]         pos_sec_o
);

    localparam int FMT_LEN = SPT * SEC_BYTES;
    localparam int CNT_W   = $clog2(FMT_LEN + 1);

    typedef struct packed {
        eng_state_e         st;
        logic [2:0]         idx;
        logic [2:0]         op;
        logic [DRV_W-1:0]   drv;
        logic [7:0]         nrec;
        logic [7:0]         trk;
        logic [7:0]         sec;
        logic [HADDR_W-1:0] bufa;
        logic [HADDR_W-1:0] haddr;
        logic [OFF_W-1:0]   ioff;
        logic [CNT_W-1:0]   bcnt;
        logic [7:0]         rcnt;
        logic [7:0]         data;
        logic [1:0]         rtype;
        logic [7:0]         err;
        logic               irq;
        logic               done;
    } eng_t;

    eng_t n_d, n_q;

    logic             chk_ok;
    logic [7:0]       chk_err;
    logic [OFF_W-1:0] img_off;
    logic             pos_upd;
    logic [7:0]       pos_trk_new;

    pbde_check #(
        .NDRV(NDRV), .SPT(SPT), .LAST_TRK(LAST_TRK), .DRV_W(DRV_W)
    ) u_check (
        .op_i   (n_q.op),
        .drv_i  (n_q.drv),
        .nrec_i (n_q.nrec),
        .trk_i  (n_q.trk),
        .sec_i  (n_q.sec),
        .rdy_i  (drv_ready_i),
        .wp_i   (drv_wprot_i),
        .ok_o   (chk_ok),
        .err_o  (chk_err)
    );

    pbde_offset #(
        .SPT(SPT), .SEC_BYTES(SEC_BYTES), .OFF_W(OFF_W)
    ) u_offset (
        .trk_i (n_q.trk),
        .sec_i (n_q.sec),
        .off_o (img_off)
    );

    pbde_headpos #(
        .NDRV(NDRV), .DRV_W(DRV_W)
    ) u_headpos (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_i (pos_upd),
        .drv_i (n_q.drv),
        .trk_i (pos_trk_new),
        .sec_i (n_q.sec),
        .sel_i (pos_sel_i),
        .trk_o (pos_trk_o),
        .sec_o (pos_sec_o)
    );

    function automatic eng_t complete(eng_t s, logic [7:0] e);
        eng_t r;
        r       = s;
        r.st    = ST_IDLE;
        r.done  = 1'b1;
        r.irq   = 1'b1;
        r.err   = e;
        r.rtype = (e == EB_NONE) ? RT_DONE : RT_FAIL;
        return r;
    endfunction

    // one data byte finished: advance addresses and byte/record counters
    function automatic eng_t step_byte(eng_t s, eng_state_e nxt);
        eng_t r;
        r       = s;
        r.haddr = s.haddr + HADDR_W'(1);
        r.ioff  = s.ioff + OFF_W'(1);
        if (s.bcnt == CNT_W'(SEC_BYTES - 1)) begin
            r.bcnt = '0;
            if (s.rcnt == 8'd1) begin
                r = complete(r, EB_NONE);
            end else begin
                r.rcnt = s.rcnt - 8'd1;
                r.st   = nxt;
            end
        end else begin
            r.bcnt = s.bcnt + CNT_W'(1);
            r.st   = nxt;
        end
        return r;
    endfunction

    always_comb begin
        n_d         = n_q;
        n_d.done    = 1'b0;
        pos_upd     = 1'b0;
        pos_trk_new = (n_q.op == OP_RECAL) ? 8'd0 : n_q.trk;
        if (irq_clr_i) begin
            n_d.irq = 1'b0;
        end
        case (n_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n_d.st    = ST_FETCH;
                    n_d.idx   = 3'd0;
                    n_d.haddr = pb_base_i;
                end
            end
            ST_FETCH: begin
                if (hm_ready_i) begin
                    case (n_q.idx)
                        3'd1: begin
                            n_d.op  = hm_rdata_i[2:0];
                            n_d.drv = hm_rdata_i[4 +: DRV_W];
                        end
                        3'd2: n_d.nrec = hm_rdata_i;
                        3'd3: n_d.trk  = hm_rdata_i;
                        3'd4: n_d.sec  = hm_rdata_i;
                        3'd5: n_d.bufa[7:0]  = hm_rdata_i;
                        3'd6: n_d.bufa[15:8] = hm_rdata_i;
                        default: ;
                    endcase
                    if (n_q.idx == 3'(PB_LAST)) begin
                        n_d.st = ST_CHECK;
                    end else begin
                        n_d.idx   = n_q.idx + 3'd1;
                        n_d.haddr = n_q.haddr + HADDR_W'(1);
                    end
                end
            end
            ST_CHECK: begin
                if (!chk_ok) begin
                    n_d = complete(n_d, chk_err);
                end else begin
                    n_d.haddr = n_q.bufa;
                    n_d.ioff  = img_off;
                    n_d.bcnt  = '0;
                    n_d.rcnt  = n_q.nrec;
                    case (n_q.op)
                        OP_SEEK, OP_RECAL: begin
                            pos_upd = 1'b1;
                            n_d     = complete(n_d, EB_NONE);
                        end
                        OP_FMT: n_d.st = ST_FILL;
                        OP_READ: begin
                            if (n_q.nrec == 8'd0) n_d = complete(n_d, EB_NONE);
                            else                  n_d.st = ST_RD_IMG;
                        end
                        OP_WRITE, OP_WRDEL: begin
                            if (n_q.nrec == 8'd0) n_d = complete(n_d, EB_NONE);
                            else                  n_d.st = ST_RD_HOST;
                        end
                        default: n_d = complete(n_d, EB_NONE);
                    endcase
                end
            end
            ST_FILL: begin
                if (hm_ready_i) begin
                    n_d.data = hm_rdata_i;
                    n_d.st   = ST_FMT_WR;
                end
            end
            ST_FMT_WR: begin
                if (im_ready_i) begin
                    n_d.ioff = n_q.ioff + OFF_W'(1);
                    if (n_q.bcnt == CNT_W'(FMT_LEN - 1)) begin
                        n_d = complete(n_d, EB_NONE);
                    end else begin
                        n_d.bcnt = n_q.bcnt + CNT_W'(1);
                    end
                end
            end
            ST_RD_IMG: begin
                if (im_ready_i) begin
                    n_d.data = im_rdata_i;
                    n_d.st   = ST_WR_HOST;
                end
            end
            ST_WR_HOST: begin
                if (hm_ready_i) n_d = step_byte(n_d, ST_RD_IMG);
            end
            ST_RD_HOST: begin
                if (hm_ready_i) begin
                    n_d.data = hm_rdata_i;
                    n_d.st   = ST_WR_IMG;
                end
            end
            ST_WR_IMG: begin
                if (im_ready_i) n_d = step_byte(n_d, ST_RD_HOST);
            end
            default: n_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q       <= '0;
            n_q.rtype <= RT_DONE;
        end else begin
            n_q <= n_d;
        end
    end

    always_comb begin
        busy_o     = (n_q.st != ST_IDLE);
        done_o     = n_q.done;
        hm_req_o   = (n_q.st == ST_FETCH) || (n_q.st == ST_FILL) ||
                     (n_q.st == ST_WR_HOST) || (n_q.st == ST_RD_HOST);
        hm_we_o    = (n_q.st == ST_WR_HOST);
        hm_addr_o  = n_q.haddr;
        hm_wdata_o = n_q.data;
        im_req_o   = (n_q.st == ST_FMT_WR) || (n_q.st == ST_RD_IMG) || (n_q.st == ST_WR_IMG);
        im_we_o    = (n_q.st == ST_FMT_WR) || (n_q.st == ST_WR_IMG);
        im_off_o   = n_q.ioff;
        im_wdata_o = n_q.data;
        res_type_o = n_q.rtype;
        res_err_o  = n_q.err;
        irq_o      = n_q.irq;
    end

    // R13: host request held steady through a stall
    a_r13_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hm_req_o && !hm_ready_i |=> hm_req_o && $stable(hm_addr_o) && $stable(hm_we_o) && $stable(hm_wdata_o));

    // R13: image request held steady through a stall
    a_r13_img_hold: assert property (@(posedge clk) disable iff (!rst_n)
        im_req_o && !im_ready_i |=> im_req_o && $stable(im_off_o) && $stable(im_we_o) && $stable(im_wdata_o));

    // R11: completion is a single-cycle pulse seen while idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R12: interrupt rises only on completion
    a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> done_o);

    // R10: a success result never carries an error code
    a_r10_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (res_type_o == RT_DONE) |-> (res_err_o == EB_NONE));

    // R13: no memory traffic while idle
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !hm_req_o && !im_req_o);

endmodule

// File: tb/pbde_engine_test.sv
module pbde_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pb_base = 16'h0;
    logic        busy, done;
    logic        hm_req, hm_we, hm_ready = 1'b0;
    logic [15:0] hm_addr;
    logic [7:0]  hm_wdata, hm_rdata = 8'h0;
    logic        im_req, im_we, im_ready = 1'b0;
    logic [18:0] im_off;
    logic [7:0]  im_wdata, im_rdata = 8'h0;
    logic [3:0]  drv_ready = 4'b1011;
    logic [3:0]  drv_wprot = 4'b0010;
    logic        irq_clr = 1'b0;
    logic [1:0]  res_type;
    logic [7:0]  res_err;
    logic        irq;
    logic [1:0]  pos_sel = 2'd0;
    logic [7:0]  pos_trk, pos_sec;

    always #10 clk = ~clk;

    pbde_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pb_base_i(pb_base),
        .busy_o(busy), .done_o(done),
        .hm_req_o(hm_req), .hm_we_o(hm_we), .hm_addr_o(hm_addr), .hm_wdata_o(hm_wdata),
        .hm_ready_i(hm_ready), .hm_rdata_i(hm_rdata),
        .im_req_o(im_req), .im_we_o(im_we), .im_off_o(im_off), .im_wdata_o(im_wdata),
        .im_ready_i(im_ready), .im_rdata_i(im_rdata),
        .drv_ready_i(drv_ready), .drv_wprot_i(drv_wprot), .irq_clr_i(irq_clr),
        .res_type_o(res_type), .res_err_o(res_err), .irq_o(irq),
        .pos_sel_i(pos_sel), .pos_trk_o(pos_trk), .pos_sec_o(pos_sec)
    );

    int n_checks = 0;
    int n_errors = 0;
    int done_cnt = 0;

    logic [7:0] hmem [int];
    logic [7:0] imem [int];
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [1:0] rt;
        logic [7:0] er;
        string      req;
    } exp_t;
    exp_t exp_q [$];

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] hget(input int a);
        return hmem.exists(a) ? hmem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] iget(input int a);
        return imem.exists(a) ? imem[a] : 8'h00;
    endfunction

    function automatic int img_at(input int trk, input int sec);
        return ((trk * 52) + (sec - 1)) * 128;
    endfunction

    // memory models: decide ready, commit writes and present read data between edges
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hm_ready = lfsr[0] | lfsr[5];
        im_ready = lfsr[3] | lfsr[9];
        if (hm_req && hm_we && hm_ready) hmem[int'(hm_addr)] = hm_wdata;
        if (im_req && im_we && im_ready) imem[int'(im_off)] = im_wdata;
        hm_rdata = hget(int'(hm_addr));
        im_rdata = iget(int'(im_off));
    end

    // monitor: compare each completion against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            done_cnt++;
            if (exp_q.size() == 0) begin
                check("R11 unexpected completion", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check({e.req, " result type"}, int'(res_type), int'(e.rt));
                check({e.req, " error byte"}, int'(res_err), int'(e.er));
                check({e.req, " R12 irq on completion"}, int'(irq), 1);
            end
        end
    end

    task automatic put_pb(input int base, input logic [2:0] op, input logic [1:0] drv,
                          input logic [7:0] nrec, input logic [7:0] trk, input logic [7:0] sec,
                          input logic [15:0] bufa);
        hmem[base]     = 8'hC8;
        hmem[base + 1] = {2'b11, drv, 1'b1, op};
        hmem[base + 2] = nrec;
        hmem[base + 3] = trk;
        hmem[base + 4] = sec;
        hmem[base + 5] = bufa[7:0];
        hmem[base + 6] = bufa[15:8];
    endtask

    task automatic run_cmd(input int base, input logic [2:0] op, input logic [1:0] drv,
                           input logic [7:0] nrec, input logic [7:0] trk, input logic [7:0] sec,
                           input logic [15:0] bufa, input logic [1:0] rt, input logic [7:0] er,
                           input string req);
        int n0;
        exp_t e;
        put_pb(base, op, drv, nrec, trk, sec, bufa);
        e.rt = rt; e.er = er; e.req = req;
        exp_q.push_back(e);
        n0 = done_cnt;
        @(negedge clk);
        pb_base = 16'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == n0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int bad;
        int base_off;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 result type", int'(res_type), 2);
        check("R1 error byte", int'(res_err), 0);
        check("R1 head track", int'(pos_trk), 0);
        check("R1 head sector", int'(pos_sec), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done idle", int'(done), 0);

        // R10 no-op
        run_cmd(32'h100, 3'd0, 2'd0, 8'd0, 8'd0, 8'd1, 16'h0, 2'b10, 8'h00, "R10 no-op");
        // R3 not ready wins over an illegal sector
        run_cmd(32'h110, 3'd4, 2'd2, 8'd1, 8'd0, 8'd0, 16'h0, 2'b00, 8'h80, "R3 not ready");
        // R4 address checks
        run_cmd(32'h120, 3'd1, 2'd0, 8'd0, 8'd5, 8'd0, 16'h0, 2'b00, 8'h08, "R4 sector zero");
        run_cmd(32'h130, 3'd1, 2'd0, 8'd0, 8'd5, 8'd53, 16'h0, 2'b00, 8'h08, "R4 sector 53");
        run_cmd(32'h140, 3'd4, 2'd0, 8'd4, 8'd5, 8'd50, 16'h0, 2'b00, 8'h08, "R4 span past track");
        run_cmd(32'h150, 3'd1, 2'd0, 8'd0, 8'd77, 8'd1, 16'h0, 2'b00, 8'h08, "R4 track 77");

        // R9 seek then recalibrate with illegal fields
        run_cmd(32'h160, 3'd1, 2'd3, 8'd0, 8'd40, 8'd7, 16'h0, 2'b10, 8'h00, "R9 seek");
        pos_sel = 2'd3;
        @(negedge clk);
        check("R9 seek track", int'(pos_trk), 40);
        check("R9 seek sector", int'(pos_sec), 7);
        run_cmd(32'h170, 3'd3, 2'd3, 8'd0, 8'd99, 8'd9, 16'h0, 2'b10, 8'h00, "R9 recalibrate");
        @(negedge clk);
        check("R9 recal track", int'(pos_trk), 0);
        check("R9 recal sector", int'(pos_sec), 9);
        pos_sel = 2'd0;
        @(negedge clk);
        check("R9 other drive untouched", int'(pos_trk), 0);

        // R5 write protect
        run_cmd(32'h180, 3'd6, 2'd1, 8'd1, 8'd2, 8'd1, 16'h0300, 2'b00, 8'h20, "R5 write protected");
        run_cmd(32'h190, 3'd2, 2'd1, 8'd0, 8'd2, 8'd1, 16'h0300, 2'b00, 8'h20, "R5 format protected");
        run_cmd(32'h1A0, 3'd7, 2'd1, 8'd1, 8'd2, 8'd1, 16'h0300, 2'b00, 8'h20, "R5 write-deleted protected");
        run_cmd(32'h1B0, 3'd6, 2'd1, 8'd1, 8'd2, 8'd0, 16'h0300, 2'b00, 8'h08, "R5 address before protect");
        check("R5 image untouched", imem.num(), 0);

        // R6 two-record write, under stalls (R13)
        for (int i = 0; i < 256; i++) hmem[32'h300 + i] = 8'(i * 7 + 3);
        run_cmd(32'h1C0, 3'd6, 2'd0, 8'd2, 8'd3, 8'd5, 16'h0300, 2'b10, 8'h00, "R6 write");
        base_off = img_at(3, 5);
        bad = 0;
        for (int i = 0; i < 256; i++) if (iget(base_off + i) != 8'(i * 7 + 3)) bad++;
        check("R6 R13 written bytes wrong", bad, 0);
        check("R6 byte before untouched", int'(imem.exists(base_off - 1)), 0);
        check("R6 byte after untouched", int'(imem.exists(base_off + 256)), 0);

        // R6 write-deleted into last sector of last track
        for (int i = 0; i < 128; i++) hmem[32'h500 + i] = 8'(8'hF0 ^ i);
        run_cmd(32'h1D0, 3'd7, 2'd3, 8'd1, 8'd76, 8'd52, 16'h0500, 2'b10, 8'h00, "R6 write-deleted last sector");
        check("R6 last sector first byte", int'(iget(img_at(76, 52))), 32'hF0);
        check("R6 last sector last byte", int'(iget(img_at(76, 52) + 127)), int'(8'hF0 ^ 8'd127));

        // R7 read back, R2 little-endian buffer address 0x0800
        run_cmd(32'h1E0, 3'd4, 2'd0, 8'd2, 8'd3, 8'd5, 16'h0800, 2'b10, 8'h00, "R7 read");
        bad = 0;
        for (int i = 0; i < 256; i++) if (hget(32'h800 + i) != 8'(i * 7 + 3)) bad++;
        check("R7 read bytes wrong", bad, 0);
        check("R2 buffer start from bytes 5 and 6", int'(hget(32'h800)), 3);
        check("R7 host past buffer untouched", int'(hmem.exists(32'h900)), 0);
        run_cmd(32'h1F0, 3'd4, 2'd0, 8'd0, 8'd3, 8'd5, 16'h0A80, 2'b10, 8'h00, "R7 zero records");
        check("R7 zero records no transfer", int'(hmem.exists(32'hA80)), 0);

        // R8 format track 1 from sector 1
        hmem[32'hA00] = 8'h5A;
        run_cmd(32'h200, 3'd2, 2'd0, 8'd0, 8'd1, 8'd1, 16'h0A00, 2'b10, 8'h00, "R8 format");
        base_off = img_at(1, 1);
        bad = 0;
        for (int i = 0; i < 6656; i++) if (iget(base_off + i) != 8'h5A) bad++;
        check("R8 fill bytes wrong", bad, 0);
        check("R8 byte after fill untouched", int'(imem.exists(base_off + 6656)), 0);
        check("R8 byte before fill untouched", int'(imem.exists(base_off - 1)), 0);

        // R10 verify
        run_cmd(32'h210, 3'd5, 2'd3, 8'd1, 8'd0, 8'd1, 16'h0, 2'b10, 8'h00, "R10 verify");

        // R11 start while busy is ignored
        begin
            int n0;
            exp_t e;
            put_pb(32'h220, 3'd4, 2'd0, 8'd1, 8'd3, 8'd5, 16'h0C00);
            put_pb(32'h230, 3'd0, 2'd2, 8'd0, 8'd0, 8'd1, 16'h0);
            e.rt = 2'b10; e.er = 8'h00; e.req = "R11 first command";
            exp_q.push_back(e);
            n0 = done_cnt;
            @(negedge clk);
            pb_base = 16'h0220; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            check("R11 busy while running", int'(busy), 1);
            pb_base = 16'h0230; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (done_cnt == n0) @(negedge clk);
            repeat (40) @(negedge clk);
            check("R11 single completion", done_cnt - n0, 1);
            check("R11 idle after done", int'(busy), 0);
        end

        // R12 interrupt clear
        check("R12 irq held", int'(irq), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R12 irq cleared", int'(irq), 0);
        check("R12 result kept", int'(res_type), 2);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule